// File: doc/BRIEF.md
# External Asynchronous Bus Timing Controller

This block turns single internal read and write requests into cycles on an external asynchronous memory bus. Each cycle has three phases counted in periods of the timing clock: a lead phase where the chip select and address settle, an active phase where the read or write strobe is asserted, and a trail phase where the chip select is held before release. Reads and writes have separate phase-length settings. A doubling control multiplies every phase count by two. One of three chip-select zones is chosen per request.

The block also produces the bus output clock, either equal to the timing clock or at half its rate. In half-rate mode every access must start its lead phase just after a rising edge of the bus output clock, so an inactive cycle is inserted when the request arrives in the wrong half. Between accesses the address bus keeps the last address with bit 0 forced high. The active phase can be stretched by an external asynchronous ready input, which is brought into the clock domain through two flops. On a 16-bit bus the upper write strobe pin carries address bit 0. A one-cycle done pulse returns the captured read data.

Top module: `xbus_timing_ctrl`

## Requirements
- R1: While reset is held, every chip select, read strobe and write strobe is high, the direction line is high, the data output enable is low, the address bus reads 0x00001, `rsp_done` is low and `req_ready` is high.
- R2: Zone code 0, 1 and 2 pulls `bus_cs_n[0]`, `bus_cs_n[1]` and `bus_cs_n[2]` low respectively; code 3 selects `bus_cs_n[2]`. At most one chip select is ever low.
- R3: The selected chip select stays low for exactly lead + active + trail timing-clock periods, taken from the read settings for reads and the write settings for writes, when ready is not in use.
- R4: `bus_rd_n` is low only in the active phase of a read; write strobes are low only in the active phase of a write. `bus_rnw` is low for the whole span of a write and high at all other times; during a write `bus_dout_en` is high and `bus_dout` carries the write data.
- R5: In full-rate mode `bus_clk_out` equals the timing clock and the lead phase begins in the cycle after the request is accepted. In half-rate mode the lead phase always begins in a cycle where `bus_clk_out` is high; if `bus_clk_out` is high in the cycle the request is accepted, one inactive cycle precedes the lead phase.
- R6: During an access the address bus carries the full request address; in every other cycle, including the inserted alignment cycle, it carries the latest request address with bit 0 forced to 1.
- R7: With `cfg_bus32` high, `bus_we0_n` strobes when lane enable bit 0 is set and `bus_we1_n` when lane enable bit 1 is set. With `cfg_bus32` low, `bus_we0_n` strobes on every write and `bus_we1_n` always equals `bus_addr[0]`.
- R8: With ready enabled and asynchronous mode selected, the active phase ends only after a cycle in which the ready input, delayed by two flops, is high; a ready line that rises once the programmed active count is spent ends the active phase exactly two periods later.
- R9: A low ready input has no effect when the ready enable is low or when the synchronous ready mode is selected.
- R10: `rsp_done` is high for exactly one cycle, the cycle right after the trail phase. For reads `rsp_rdata` then holds `bus_din` as sampled at the end of the active phase, with the upper 16 bits zero in 16-bit mode.
- R11: With `cfg_x2` high, each phase lasts twice its programmed count.
- R12: A programmed phase count of 0 gives a phase of one period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rd_lead | input | 3 | Read lead count |
| cfg_rd_active | input | 3 | Read active count |
| cfg_rd_trail | input | 3 | Read trail count |
| cfg_wr_lead | input | 3 | Write lead count |
| cfg_wr_active | input | 3 | Write active count |
| cfg_wr_trail | input | 3 | Write trail count |
| cfg_x2 | input | 1 | Double every phase count |
| cfg_half_rate | input | 1 | Bus clock at half the timing clock rate |
| cfg_bus32 | input | 1 | 32-bit data bus (low: 16-bit) |
| cfg_use_ready | input | 1 | Honour the ready input |
| cfg_ready_async | input | 1 | Ready mode: 1 asynchronous, 0 synchronous |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_zone | input | 2 | Zone code |
| req_addr | input | 20 | Request address |
| req_wdata | input | 32 | Write data |
| req_lane_en | input | 2 | Halfword lane enables for 32-bit writes |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| rsp_done | output | 1 | Access finished pulse |
| rsp_rdata | output | 32 | Captured read data |
| bus_clk_out | output | 1 | Bus output clock |
| bus_cs_n | output | 3 | Zone chip selects, active low |
| bus_addr | output | 20 | External address |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we0_n | output | 1 | Lower write strobe, active low |
| bus_we1_n | output | 1 | Upper write strobe or address bit 0 |
| bus_rnw | output | 1 | Direction, high for read |
| bus_dout | output | 32 | Write data to the bus |
| bus_dout_en | output | 1 | Data output enable |
| bus_din | input | 32 | Read data from the bus |
| bus_ready | input | 1 | Asynchronous ready |

## Verification
A phase counter that loads the wrong length or misses its terminal value shows up in the very access it affects as a chip-select or strobe window of the wrong width, so the bench measures these windows cycle by cycle for every access pattern. A wrong bus-clock phase decision appears as a lead phase starting with the bus clock low or as an extra or missing inactive cycle before the chip select falls, visible in the first cycles of a half-rate access. A stale or misrouted request register shows within the same access as a wrong zone, address, direction or data value, and a broken ready path appears as an active window that ends too early or never ends, caught against the exact two-period delay after ready rises.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ALIGN  = 3'd1,
    PH_LEAD   = 3'd2,
    PH_ACTIVE = 3'd3,
    PH_TRAIL  = 3'd4
  } phase_e;

endpackage

// File: rtl/xbus_reset_sync.sv
module xbus_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end

endmodule

// File: rtl/xbus_clkgen.sv
module xbus_clkgen (
  input  logic clk,
  input  logic rst_n,
  output logic bclk_q
);

  logic bclk_d;

  always_comb begin
    bclk_d = ~bclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
    end else begin
      bclk_q <= bclk_d;
    end
  end

endmodule

// File: rtl/xbus_ready_sync.sv
module xbus_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_in,
  output logic ready_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], ready_in};
    end
  end

  assign ready_sync = chain_q[STAGES-1];

endmodule

// File: rtl/xbus_phase_fsm.sv
module xbus_phase_fsm
  import xbus_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             need_align,
  input  logic [LEN_W-1:0] lead_len,
  input  logic [LEN_W-1:0] act_len,
  input  logic [LEN_W-1:0] trail_len,
  input  logic             ready_ok,
  output phase_e           phase,
  output logic             act_end,
  output logic             done
);

  phase_e           ph_q, ph_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             done_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    act_end = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          if (need_align) begin
            ph_d = PH_ALIGN;
          end else begin
            ph_d  = PH_LEAD;
            cnt_d = lead_len - LEN_W'(1);
          end
        end
      end
      PH_ALIGN: begin
        ph_d  = PH_LEAD;
        cnt_d = lead_len - LEN_W'(1);
      end
      PH_LEAD: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - LEN_W'(1);
        end else begin
          ph_d  = PH_ACTIVE;
          cnt_d = act_len - LEN_W'(1);
        end
      end
      PH_ACTIVE: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - LEN_W'(1);
        end else if (ready_ok) begin
          act_end = 1'b1;
          ph_d    = PH_TRAIL;
          cnt_d   = trail_len - LEN_W'(1);
        end
      end
      PH_TRAIL: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - LEN_W'(1);
        end else begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      done  <= done_d;
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/xbus_timing_ctrl.sv
module xbus_timing_ctrl
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3,
  parameter int NZONE  = 3,
  parameter int ZSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_rd_lead,
  input  logic [CNT_W-1:0]  cfg_rd_active,
  input  logic [CNT_W-1:0]  cfg_rd_trail,
  input  logic [CNT_W-1:0]  cfg_wr_lead,
  input  logic [CNT_W-1:0]  cfg_wr_active,
  input  logic [CNT_W-1:0]  cfg_wr_trail,
  input  logic              cfg_x2,
  input  logic              cfg_half_rate,
  input  logic              cfg_bus32,
  input  logic              cfg_use_ready,
  input  logic              cfg_ready_async,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ZSEL_W-1:0] req_zone,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_lane_en,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_clk_out,
  output logic [NZONE-1:0]  bus_cs_n,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd_n,
  output logic              bus_we0_n,
  output logic              bus_we1_n,
  output logic              bus_rnw,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_en,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              bus_ready
);

  localparam int LEN_W  = CNT_W + 1;
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [LEN_W-1:0] scale_len(input logic [CNT_W-1:0] v,
                                                 input logic x2);
    logic [LEN_W-1:0] r;
    r = x2 ? {v, 1'b0} : {1'b0, v};
    if (r == '0) begin
      r = LEN_W'(1);
    end
    return r;
  endfunction

  logic              rst_n_s;
  logic              bclk_q;
  logic              ready_s;
  phase_e            phase;
  logic              act_end;
  logic              accept;
  logic              dir_wr;
  logic              in_cyc;
  logic              strobe;
  logic              ready_ok;
  logic [LEN_W-1:0]  lead_len, act_len, trail_len;

  logic              wr_q;
  logic [ZSEL_W-1:0] zone_q, zone_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        lane_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              capture;

  xbus_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  xbus_clkgen u_clk (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .bclk_q (bclk_q)
  );

  xbus_ready_sync #(.STAGES(2)) u_rdy (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .ready_in   (bus_ready),
    .ready_sync (ready_s)
  );

  // Timing set follows the incoming request while idle, the held one after.
  assign dir_wr    = (phase == PH_IDLE) ? req_write : wr_q;
  assign lead_len  = scale_len(dir_wr ? cfg_wr_lead   : cfg_rd_lead,   cfg_x2);
  assign act_len   = scale_len(dir_wr ? cfg_wr_active : cfg_rd_active, cfg_x2);
  assign trail_len = scale_len(dir_wr ? cfg_wr_trail  : cfg_rd_trail,  cfg_x2);
  assign ready_ok  = ~(cfg_use_ready & cfg_ready_async) | ready_s;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid & req_ready;

  xbus_phase_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start      (accept),
    .need_align (cfg_half_rate & bclk_q),
    .lead_len   (lead_len),
    .act_len    (act_len),
    .trail_len  (trail_len),
    .ready_ok   (ready_ok),
    .phase      (phase),
    .act_end    (act_end),
    .done       (rsp_done)
  );

  // Request holding registers.
  always_comb begin
    zone_d = (req_zone >= ZSEL_W'(NZONE)) ? ZSEL_W'(NZONE - 1) : req_zone;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_q    <= 1'b0;
      zone_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      lane_q  <= '0;
    end else if (accept) begin
      wr_q    <= req_write;
      zone_q  <= zone_d;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      lane_q  <= req_lane_en;
    end
  end

  // Read data capture at the edge that closes the active phase.
  assign capture = act_end & ~wr_q;

  always_comb begin
    if (cfg_bus32) begin
      rdata_d = bus_din;
    end else begin
      rdata_d = {{(DATA_W - HALF_W){1'b0}}, bus_din[HALF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= rdata_d;
    end
  end

  assign rsp_rdata = rdata_q;

  // Pin drive.
  assign in_cyc = (phase == PH_LEAD) || (phase == PH_ACTIVE) || (phase == PH_TRAIL);
  assign strobe = (phase == PH_ACTIVE);

  assign bus_clk_out = cfg_half_rate ? bclk_q : clk;

  for (genvar z = 0; z < NZONE; z++) begin : g_cs
    assign bus_cs_n[z] = ~(in_cyc && (zone_q == ZSEL_W'(z)));
  end

  assign bus_addr    = in_cyc ? addr_q : {addr_q[ADDR_W-1:1], 1'b1};
  assign bus_rd_n    = ~(strobe & ~wr_q);
  assign bus_we0_n   = ~(strobe & wr_q & (lane_q[0] | ~cfg_bus32));
  assign bus_we1_n   = cfg_bus32 ? ~(strobe & wr_q & lane_q[1]) : bus_addr[0];
  assign bus_rnw     = ~(in_cyc & wr_q);
  assign bus_dout_en = in_cyc & wr_q;
  assign bus_dout    = wdata_q;

endmodule

// File: rtl/xbus_timing_chk.sv
module xbus_timing_chk #(
  parameter int NZONE = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_half_rate,
  input logic             cfg_bus32,
  input logic             bus_clk_out,
  input logic [NZONE-1:0] bus_cs_n,
  input logic             bus_addr0,
  input logic             bus_rd_n,
  input logic             bus_we0_n,
  input logic             bus_we1_n,
  input logic             bus_rnw,
  input logic             rsp_done
);

  logic cs_act;
  assign cs_act = ~&bus_cs_n;

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n)); // R2

  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_we0_n) |-> cs_act); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_we0_n)); // R4

  AST_RNW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act)) |-> $stable(bus_rnw)); // R4

  AST_ALIGN_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_half_rate && $rose(cs_act)) |-> bus_clk_out); // R5

  AST_IDLE_ADDR0: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> bus_addr0); // R6

  AST_WE1_ADDR0: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_bus32 |-> (bus_we1_n == bus_addr0)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R10

  AST_DONE_AFTER_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (!cs_act && $past(cs_act))); // R10

endmodule

bind xbus_timing_ctrl xbus_timing_chk #(.NZONE(NZONE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_half_rate (cfg_half_rate),
  .cfg_bus32     (cfg_bus32),
  .bus_clk_out   (bus_clk_out),
  .bus_cs_n      (bus_cs_n),
  .bus_addr0     (bus_addr[0]),
  .bus_rd_n      (bus_rd_n),
  .bus_we0_n     (bus_we0_n),
  .bus_we1_n     (bus_we1_n),
  .bus_rnw       (bus_rnw),
  .rsp_done      (rsp_done)
);

// File: tb/tb_xbus_timing_ctrl.sv
module tb_xbus_timing_ctrl;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [1:0]  zone;
    logic [2:0]  lead;
    logic [2:0]  act;
    logic [2:0]  trail;
    logic        half;
    logic        b32;
    logic        x2;
    logic [1:0]  lane;
    logic [19:0] addr;
    logic [31:0] data;
    logic [4:0]  exp_cs;
    logic [4:0]  exp_act;
  } vec_t;

  // wr zone lead act trail half b32 x2 lane addr data exp_cs exp_act
  localparam vec_t VECS [0:6] = '{
    '{1'b0, 2'd0, 3'd1, 3'd3, 3'd1, 1'b0, 1'b1, 1'b0, 2'b11, 20'h12345, 32'hA5A55A5A, 5'd5,  5'd3},
    '{1'b1, 2'd1, 3'd2, 3'd4, 3'd2, 1'b0, 1'b1, 1'b0, 2'b10, 20'hABCDE, 32'h12345678, 5'd8,  5'd4},
    '{1'b0, 2'd2, 3'd1, 3'd3, 3'd1, 1'b1, 1'b1, 1'b0, 2'b11, 20'h00F01, 32'hCAFEF00D, 5'd5,  5'd3},
    '{1'b0, 2'd3, 3'd0, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 2'b11, 20'h00F0E, 32'h89AB4321, 5'd3,  5'd1},
    '{1'b1, 2'd0, 3'd1, 3'd2, 3'd3, 1'b0, 1'b0, 1'b1, 2'b01, 20'h54320, 32'hDEAD1234, 5'd12, 5'd4},
    '{1'b1, 2'd1, 3'd3, 3'd3, 3'd2, 1'b1, 1'b1, 1'b0, 2'b11, 20'h7FFFF, 32'h0BADBEEF, 5'd8,  5'd3},
    '{1'b0, 2'd1, 3'd2, 3'd3, 3'd1, 1'b1, 1'b1, 1'b0, 2'b11, 20'h2468A, 32'h13579BDF, 5'd6,  5'd3}
  };

  logic        clk;
  logic        rst_n;
  logic [2:0]  cfg_rd_lead, cfg_rd_active, cfg_rd_trail;
  logic [2:0]  cfg_wr_lead, cfg_wr_active, cfg_wr_trail;
  logic        cfg_x2, cfg_half_rate, cfg_bus32, cfg_use_ready, cfg_ready_async;
  logic        req_valid, req_write;
  logic [1:0]  req_zone;
  logic [19:0] req_addr;
  logic [31:0] req_wdata;
  logic [1:0]  req_lane_en;
  logic        req_ready, rsp_done;
  logic [31:0] rsp_rdata;
  logic        bus_clk_out;
  logic [2:0]  bus_cs_n;
  logic [19:0] bus_addr;
  logic        bus_rd_n, bus_we0_n, bus_we1_n, bus_rnw, bus_dout_en;
  logic [31:0] bus_dout, bus_din;
  logic        bus_ready;

  int n_chk;
  int n_fail;
  bit finished;

  xbus_timing_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_lead(cfg_rd_lead), .cfg_rd_active(cfg_rd_active), .cfg_rd_trail(cfg_rd_trail),
    .cfg_wr_lead(cfg_wr_lead), .cfg_wr_active(cfg_wr_active), .cfg_wr_trail(cfg_wr_trail),
    .cfg_x2(cfg_x2), .cfg_half_rate(cfg_half_rate), .cfg_bus32(cfg_bus32),
    .cfg_use_ready(cfg_use_ready), .cfg_ready_async(cfg_ready_async),
    .req_valid(req_valid), .req_write(req_write), .req_zone(req_zone),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_lane_en(req_lane_en),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_clk_out(bus_clk_out), .bus_cs_n(bus_cs_n), .bus_addr(bus_addr),
    .bus_rd_n(bus_rd_n), .bus_we0_n(bus_we0_n), .bus_we1_n(bus_we1_n),
    .bus_rnw(bus_rnw), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_din(bus_din), .bus_ready(bus_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_access(input vec_t v, input int rise_at);
    int lat = 0, csn = 0, stb = 0, we1c = 0;
    int bad_zone = 0, bad_rnw = 0, bad_addr = 0, bad_dout = 0, bad_w1 = 0;
    bit started = 1'b0, got_done = 1'b0, pre = 1'b0, first_bclk = 1'b0;
    int zexp;
    int exp_stb, exp_we1, exp_lat;
    logic [19:0] idle_addr;
    logic [31:0] exp_rd;
    zexp      = (v.zone > 2'd2) ? 2 : int'(v.zone);
    idle_addr = {v.addr[19:1], 1'b1};
    @(negedge clk);
    cfg_rd_lead   = v.wr ? 3'd7 : v.lead;
    cfg_rd_active = v.wr ? 3'd7 : v.act;
    cfg_rd_trail  = v.wr ? 3'd7 : v.trail;
    cfg_wr_lead   = v.wr ? v.lead  : 3'd7;
    cfg_wr_active = v.wr ? v.act   : 3'd7;
    cfg_wr_trail  = v.wr ? v.trail : 3'd7;
    cfg_half_rate = v.half;
    cfg_bus32     = v.b32;
    cfg_x2        = v.x2;
    req_write     = v.wr;
    req_zone      = v.zone;
    req_addr      = v.addr;
    req_wdata     = v.data;
    req_lane_en   = v.lane;
    bus_din       = v.data;
    req_valid     = 1'b1;
    #1;
    pre = bus_clk_out;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (rsp_done) begin
        got_done = 1'b1;
        if (bus_addr != idle_addr) bad_addr++;
        break;
      end
      if (~&bus_cs_n) begin
        if (!started) begin
          started    = 1'b1;
          first_bclk = bus_clk_out;
        end
        csn++;
        if (bus_cs_n != ~(3'b001 << zexp)) bad_zone++;
        if (bus_rnw != !v.wr) bad_rnw++;
        if (bus_addr != v.addr) bad_addr++;
        if (v.wr && (!bus_dout_en || bus_dout != v.data)) bad_dout++;
        if (!v.wr && !bus_rd_n) stb++;
        if (v.wr && !bus_we0_n) stb++;
        if (v.b32 && !bus_we1_n) we1c++;
      end else begin
        if (!started) lat++;
        if (bus_addr != idle_addr) bad_addr++;
        if (!bus_rnw || !bus_rd_n || !bus_we0_n || bus_dout_en) bad_rnw++;
      end
      if (!v.b32 && (bus_we1_n != bus_addr[0])) bad_w1++;
      if (rise_at != 0 && stb == rise_at) bus_ready = 1'b1;
      @(negedge clk);
    end
    exp_lat = (v.half && pre) ? 1 : 0;
    exp_stb = (!v.wr || v.lane[0] || !v.b32) ? int'(v.exp_act) : 0;
    exp_we1 = (v.wr && v.b32 && v.lane[1]) ? int'(v.exp_act) : 0;
    exp_rd  = v.b32 ? v.data : {16'h0000, v.data[15:0]};
    chk(lat == exp_lat, "R5 cycles before lead", lat, exp_lat);
    if (v.half) chk(first_bclk, "R5 bus clock high at lead start", first_bclk, 1);
    chk(csn == int'(v.exp_cs), "R3/R11/R12 chip select span", csn, v.exp_cs);
    chk(stb == exp_stb, "R4/R8/R9 strobe span", stb, exp_stb);
    if (v.b32) chk(we1c == exp_we1, "R7 upper lane strobe span", we1c, exp_we1);
    else       chk(bad_w1 == 0, "R7 upper strobe pin as addr bit0", bad_w1, 0);
    chk(bad_zone == 0, "R2 zone select", bad_zone, 0);
    chk(bad_rnw == 0, "R4 direction and idle strobes", bad_rnw, 0);
    chk(bad_addr == 0, "R6 address bus", bad_addr, 0);
    if (v.wr) chk(bad_dout == 0, "R4 write data drive", bad_dout, 0);
    chk(got_done, "R10 done seen", got_done, 1);
    if (!v.wr) chk(rsp_rdata == exp_rd, "R10 read data", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(!rsp_done, "R10 done one cycle", rsp_done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    vec_t rv;
    n_chk = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0;
    cfg_rd_lead = 3'd1; cfg_rd_active = 3'd3; cfg_rd_trail = 3'd1;
    cfg_wr_lead = 3'd1; cfg_wr_active = 3'd3; cfg_wr_trail = 3'd1;
    cfg_x2 = 1'b0; cfg_half_rate = 1'b0; cfg_bus32 = 1'b1;
    cfg_use_ready = 1'b0; cfg_ready_async = 1'b1;
    req_valid = 1'b0; req_write = 1'b0; req_zone = 2'd0;
    req_addr = '0; req_wdata = '0; req_lane_en = 2'b11;
    bus_din = '0; bus_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_cs_n == 3'b111, "R1 chip selects", bus_cs_n, 3'b111);
    chk(bus_rd_n && bus_we0_n && bus_we1_n, "R1 strobes",
        {bus_rd_n, bus_we0_n, bus_we1_n}, 3'b111);
    chk(bus_rnw && !bus_dout_en, "R1 direction and enable", {bus_rnw, bus_dout_en}, 2'b10);
    chk(bus_addr == 20'h00001, "R1 address", bus_addr, 20'h00001);
    chk(!rsp_done && req_ready, "R1 done and ready", {rsp_done, req_ready}, 2'b01);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < 7; k++) begin
      do_access(VECS[k], 0);
    end

    // R8 ready stretch: raise ready after 8 active cycles, expect 10
    cfg_use_ready = 1'b1; cfg_ready_async = 1'b1; bus_ready = 1'b0;
    repeat (4) @(negedge clk);
    rv = '{1'b0, 2'd1, 3'd1, 3'd3, 3'd1, 1'b0, 1'b1, 1'b0, 2'b11,
           20'h33333, 32'h600DD00D, 5'd12, 5'd10};
    do_access(rv, 8);

    // R9 ready ignored in synchronous mode
    bus_ready = 1'b0; cfg_ready_async = 1'b0;
    repeat (4) @(negedge clk);
    rv = '{1'b0, 2'd0, 3'd1, 3'd3, 3'd1, 1'b0, 1'b1, 1'b0, 2'b11,
           20'h11110, 32'h0F0F0F0F, 5'd5, 5'd3};
    do_access(rv, 0);

    // R9 ready ignored when disabled
    cfg_use_ready = 1'b0; cfg_ready_async = 1'b1;
    rv = '{1'b1, 2'd2, 3'd1, 3'd3, 3'd1, 1'b0, 1'b1, 1'b0, 2'b11,
           20'h22221, 32'hF0F0F0F0, 5'd5, 5'd3};
    do_access(rv, 0);
    bus_ready = 1'b1;
    repeat (4) @(negedge clk);

    report();
  end

endmodule